// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a register-access target on a three-wire serial bus. The bus has an active-low select, a serial clock and a single data line that carries traffic in both directions. Each transaction sends one direction bit, then a 7-bit register address and then a 16-bit word. A write stores the word in a 128-entry register file. A read returns the stored word on the same data line, so the block takes over the line partway through the frame and lets go of it again.

All three bus pins are brought into the system clock domain through two-flop synchronizers, and the serial clock edges are detected there. The data line is presented as three signals: the sampled input, the driven value and an output enable. The chip-level pad joins these into one bidirectional pin. A combinational lookup port lets local logic read any register in parallel, without going through the bus.

Top module: `spi3_regslave`

## Requirements
- R1: A frame begins when `csn_i` falls, and that falling edge clears the bit counter. Serial clock edges and data bits that occur while `csn_i` is high change no register.
- R2: The first bit sampled in a frame sets the direction: 1 means read and 0 means write. The next seven bits form the register address, most significant bit first.
- R3: The 16 data bits that follow the address are taken most significant bit first. Serial clock edges after the 24th bit of a frame are ignored.
- R4: Incoming bits are sampled on rising edges of `sclk_i`.
- R5: During a read, the driven bit changes only on falling edges of `sclk_i`. D15 appears on the falling edge that follows the rising edge that sampled the last address bit. Each later falling edge presents the next lower bit.
- R6: `sdio_oe` is high only in the data phase of a read frame. It stays low for the whole of every write frame and during the direction and address bits.
- R7: When `csn_i` goes high, `sdio_oe` drops at once, through combinational logic, without waiting for any clock.
- R8: A write reaches the register file only when all 16 data bits have been received. A frame cut short by `csn_i` rising leaves every register unchanged.
- R9: The register file holds 128 registers of 16 bits each, and all of them reset to zero.
- R10: `view_data` always shows the register currently selected by `view_addr`.
- R11: Each high phase and each low phase of `sclk_i` must last at least three system clock periods. Under that condition no edge is missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| csn_i | input | 1 | Bus select, active low |
| sclk_i | input | 1 | Bus serial clock |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Value the block drives onto the data line |
| sdio_oe | output | 1 | Output enable for the data line pad |
| view_addr | input | 7 | Register index for the parallel view |
| view_data | output | 16 | Contents of the register selected by `view_addr` |

## Verification
The assertions assume that the serial clock phases are long enough for the synchronizers to see every edge. They also assume that select never falls in the same system cycle as a serial clock edge is detected, and that select does not toggle between the rising and falling edges of one bit. The stimulus holds each serial clock phase for five system cycles. It changes select and data only while the serial clock is low, and it leaves a settling gap of several cycles before the first edge of a frame and after the last one. Random write and read frames run against a bench model of the register file. Directed cases cover reset contents, clocking with select high, aborted writes, aborted reads and extra clocks after the 24th bit.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int unsigned        W       = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_n [STAGES];

  always_comb begin
    stage_n[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_n[s] = stage_q[s-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_n[g];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
  import spi3_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] view_addr_i,
  output logic [DW-1:0] view_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] ent_en;

  always_comb begin
    ent_en = '0;
    if (wr_en_i) ent_en[wr_addr_i] = 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[e] <= '0;
      else if (ent_en[e]) mem_q[e] <= wr_data_i;
    end
  end

  assign rd_data_o   = mem_q[rd_addr_i];
  assign view_data_o = mem_q[view_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i)); // R8
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  csn_s_i,
  input  logic  sclk_s_i,
  input  logic  sdi_s_i,
  output addr_t rd_addr_o,
  input  word_t rd_data_i,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output word_t wr_data_o,
  output logic  sdo_o,
  output logic  oe_o
);
  localparam cnt_t LAST_ADR = cnt_t'(ADDR_W);
  localparam cnt_t LAST_BIT = cnt_t'(FRAME_BITS - 1);
  localparam cnt_t FULL     = cnt_t'(FRAME_BITS);

  logic  sclk_d_q, csn_d_q;
  logic  sclk_rise, sclk_fall, cs_fall;

  cnt_t  cnt_q, cnt_n;
  logic  rw_q, rw_n;
  addr_t addr_q, addr_n;
  word_t data_q, data_n;
  word_t shft_q, shft_n;
  logic  sdo_q, sdo_n;
  logic  oe_q, oe_n;
  logic  wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      csn_d_q  <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s_i;
      csn_d_q  <= csn_s_i;
    end
  end

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign sclk_fall = ~sclk_s_i & sclk_d_q;
  assign cs_fall   = ~csn_s_i & csn_d_q;

  always_comb begin
    cnt_n  = cnt_q;
    rw_n   = rw_q;
    addr_n = addr_q;
    data_n = data_q;
    shft_n = shft_q;
    sdo_n  = sdo_q;
    oe_n   = oe_q;
    wr_en  = 1'b0;
    if (cs_fall) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (csn_s_i) begin
      oe_n  = 1'b0;
    end else begin
      if (sclk_rise && (cnt_q < FULL)) begin
        cnt_n = cnt_q + cnt_t'(1);
        if (cnt_q == '0) begin
          rw_n = sdi_s_i;
        end else if (cnt_q <= LAST_ADR) begin
          addr_n = {addr_q[ADDR_W-2:0], sdi_s_i};
          if (cnt_q == LAST_ADR) shft_n = rd_data_i;
        end else begin
          data_n = {data_q[DATA_W-2:0], sdi_s_i};
          if ((cnt_q == LAST_BIT) && !rw_q) wr_en = 1'b1;
        end
      end
      if (sclk_fall) begin
        if (rw_q && (cnt_q > LAST_ADR) && (cnt_q < FULL)) begin
          oe_n   = 1'b1;
          sdo_n  = shft_q[DATA_W-1];
          shft_n = {shft_q[DATA_W-2:0], 1'b0};
        end else begin
          oe_n   = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= FULL;
      rw_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      shft_q <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rw_q   <= rw_n;
      addr_q <= addr_n;
      data_q <= data_n;
      shft_q <= shft_n;
      sdo_q  <= sdo_n;
      oe_q   <= oe_n;
    end
  end

  assign rd_addr_o = {addr_q[ADDR_W-2:0], sdi_s_i};
  assign wr_en_o   = wr_en;
  assign wr_addr_o = addr_q;
  assign wr_data_o = {data_q[DATA_W-2:0], sdi_s_i};
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R3
  AST_CS_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> cnt_q == '0); // R1
  AST_WRITE_AFTER_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == FULL); // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rw_q); // R6
  AST_OE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cnt_q > LAST_ADR)); // R6
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sdo_q)); // R5
endmodule

// File: rtl/spi3_regslave.sv
module spi3_regslave
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic [ADDR_W-1:0] view_addr,
  output logic [DATA_W-1:0] view_data
);
  logic  rst_n_sync;
  logic [2:0] pins_s;
  addr_t rd_addr, wr_addr;
  word_t rd_data, wr_data;
  logic  wr_en, oe_int;

  spi3_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_sync)
  );

  spi3_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_sync), .d_i({csn_i, sclk_i, sdio_i}), .q_o(pins_s)
  );

  spi3_frame u_frame (
    .clk(clk), .rst_n(rst_n_sync),
    .csn_s_i(pins_s[2]), .sclk_s_i(pins_s[1]), .sdi_s_i(pins_s[0]),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdo_o(sdio_o), .oe_o(oe_int)
  );

  spi3_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .view_addr_i(view_addr), .view_data_o(view_data)
  );

  assign sdio_oe = oe_int & ~csn_i;

  AST_NO_DRIVE_IDLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pins_s[2] && $past(pins_s[2]) |-> !oe_int); // R7
endmodule

// File: tb/tb_spi3_regslave.sv
module tb_spi3_regslave;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdio_o, sdio_oe;
  logic [6:0]  view_addr = '0;
  logic [15:0] view_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [128];

  always #5 clk = ~clk;

  spi3_regslave dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .view_addr(view_addr), .view_data(view_data)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input bit rw, input logic [6:0] a, input logic [15:0] d);
    return {rw, a, d};
  endfunction

  // Runs nbits clock cycles with select low; leaves select low at the end.
  task automatic shift_bits(input bit rw, input logic [6:0] a, input logic [15:0] d,
                            input int nbits, output logic [15:0] rd, output bit oe_ok);
    logic [23:0] fr;
    fr = pack(rw, a, d);
    rd = '0;
    oe_ok = 1'b1;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? fr[23-i] : 1'($urandom);
      wait_clk(HALF);
      if (rw && i >= 8 && i < 24) begin
        rd = {rd[14:0], sdio_o};
        if (!sdio_oe) oe_ok = 1'b0;
      end else if (sdio_oe) begin
        oe_ok = 1'b0;
      end
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic end_frame();
    csn = 1'b1;
    #1;
    chk(sdio_oe == 1'b0, "R7 oe after select high", sdio_oe, 0);
    wait_clk(6);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] rd;
    bit ok;
    shift_bits(1'b0, a, d, 24, rd, ok);
    chk(ok, "R6 no drive in write", ok, 1);
    end_frame();
    model[a] = d;
  endtask

  task automatic do_read(input logic [6:0] a, input string tag);
    logic [15:0] rd;
    bit ok;
    shift_bits(1'b1, a, 16'h0000, 24, rd, ok);
    chk(rd == model[a], tag, rd, model[a]);
    chk(ok, "R6 oe only in read data phase", ok, 1);
    end_frame();
  endtask

  task automatic view_chk(input logic [6:0] a, input string tag);
    view_addr = a;
    #1;
    chk(view_data == model[a], tag, view_data, model[a]);
  endtask

  initial begin
    logic [15:0] rd;
    bit ok;
    void'($urandom(32'h5eed_0017));
    for (int k = 0; k < 128; k++) model[k] = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R9 reset contents, R6 idle
    chk(sdio_oe == 1'b0, "R6 idle oe", sdio_oe, 0);
    view_chk(7'd0, "R9 reset reg 0");
    view_chk(7'd127, "R9 reset reg 127");
    do_read(7'd5, "R9 reset read via bus");

    // R2 R3 R4 directed write/read, MSB-first patterns
    do_write(7'h40, 16'h8001);
    view_chk(7'h40, "R2 R3 address/data MSB first");
    do_read(7'h40, "R4 R5 read back 8001");
    do_write(7'h01, 16'hA55A);
    view_chk(7'h01, "R10 view of reg 1");
    view_chk(7'h40, "R10 view of reg 0x40 unaffected");
    do_write(7'h7F, 16'hFFFF);
    do_read(7'h7F, "R5 read all ones");

    // R1 clocking with select high is ignored
    for (int i = 0; i < 30; i++) begin
      sdi = 1'($urandom);
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(4);
    chk(sdio_oe == 1'b0, "R1 no drive with select high", sdio_oe, 0);
    view_chk(7'h01, "R1 reg unchanged by clocks outside frame");
    do_read(7'h01, "R1 frame after stray clocks");

    // R8 aborted write
    shift_bits(1'b0, 7'h01, 16'h1234, 20, rd, ok);
    end_frame();
    view_chk(7'h01, "R8 aborted write leaves reg");

    // R7 aborted read: line driven, then released at once
    shift_bits(1'b1, 7'h40, 16'h0, 12, rd, ok);
    chk(sdio_oe == 1'b1, "R6 driving mid data phase", sdio_oe, 1);
    end_frame();

    // R3 extra clocks after 24th bit ignored
    shift_bits(1'b0, 7'h22, 16'hC3C3, 30, rd, ok);
    chk(ok, "R3 no drive on extra clocks", ok, 1);
    end_frame();
    model[7'h22] = 16'hC3C3;
    view_chk(7'h22, "R3 extra clocks ignored");
    shift_bits(1'b1, 7'h22, 16'h0, 28, rd, ok);
    chk(rd == 16'hC3C3, "R3 read with extra clocks", rd, 16'hC3C3);
    chk(ok, "R6 released after D0", ok, 1);
    end_frame();

    // random traffic, R11 phases kept at HALF cycles
    for (int n = 0; n < 60; n++) begin
      logic [6:0] a;
      a = 7'($urandom);
      if ($urandom % 2) begin
        do_write(a, 16'($urandom));
        view_chk(a, "R2 R8 random write");
      end else begin
        do_read(a, "R11 random read");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule